// File: doc/BRIEF.md
# Command-Driven Table Access Engine

This block lets a processor reach a set of internal lookup tables through a small register window. The window has a bank of data registers, one for each word of a table entry, and one command register. To store an entry, software fills the data registers and then writes a command that names the table, the entry and the direction, with the execute bit set. To fetch an entry, software writes a read command and waits. Either way, software polls the command register until the hardware has cleared the execute bit. After a read completes, the data registers hold the entry that was fetched.

Each command takes a fixed number of cycles, so polling software and test benches can predict when it ends. All table types share one storage model of the same geometry. For example, the spanning-tree port-state table is table type 5, and each of its entries is four 32-bit words. An entry index beyond the configured depth still completes normally. Such an access leaves storage untouched and reads back as zeros.

The register port is a plain write-strobe and address interface. It accepts every access in the cycle it is presented and never applies back-pressure. Read data is a combinational function of the address. The `busy` output mirrors the execute bit for hardware that prefers a pin to polling.

Top module: `tae_engine`

## Requirements
- R1: After reset, `busy` is 0, and every data register, the command readback and every table entry read as zero.
- R2: While idle, a write to address w (0..3) sets data register w, and a read of address w returns it.
- R3: A command written to address 4 with bit 16 set raises `busy` and readback bit 16 on the next edge. Both clear exactly LATENCY (3) cycles after the write edge.
- R4: A command with bit 15 = 1 (write) stores data registers 0..3 into entry (type = bits 14:12, index = bits 11:0) when it completes.
- R5: A command with bit 15 = 0 (read) loads that entry into data registers 0..3 by the time bit 16 clears. Entries of different types with the same index are independent.
- R6: While busy, writes to the command register and to the data registers are ignored. The running access, its fields and the data it stores are not disturbed.
- R7: An index of DEPTH (16) or more completes in the same time as any other command. A write to such an index leaves every entry unchanged, and a read from it returns zeros.
- R8: A command write with bit 16 clear starts no access and `busy` stays 0. Its bits 15:0 are still recorded.
- R9: Writes to addresses 5..7 have no effect, and reads of those addresses return zero.
- R10: Reading address 4 returns bits 15:0 of the last accepted command, with bit 16 equal to `busy` and all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0..3 data, 4 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| busy | output | 1 | Access in progress (same as command bit 16) |

## Verification
The hardest situation to reach is a register write that lands while an access is in flight. It can only happen in the few cycles between a command and its completion. The bench issues a second command and a data-register write on the cycles right after a start, then checks that the access ran as first commanded. It also checks that the entry holds the data from before the intrusion. Out-of-range indices are exercised with a write to index 16, followed by reads of index 16 and index 0, so that any wrap of the index into a valid entry shows up.

// File: rtl/tae_pkg.sv
package tae_pkg;
  // Command word field positions; software depends on these.
  localparam int EXEC_POS = 16;
  localparam int TYPE_W   = 3;
  localparam int IDX_W    = 12;
  localparam int FIELD_W  = 1 + TYPE_W + IDX_W;  // bits 15:0

  typedef struct packed {
    logic              wr;     // bit 15: 1 write, 0 read
    logic [TYPE_W-1:0] ttype;  // bits 14:12
    logic [IDX_W-1:0]  idx;    // bits 11:0
  } cmd_t;
endpackage

// File: rtl/tae_decode.sv
module tae_decode
  import tae_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int MA_W  = 7
) (
  input  cmd_t            cmd,
  output logic            in_range,
  output logic [MA_W-1:0] mem_addr
);
  always_comb begin
    in_range = int'(cmd.idx) < DEPTH;
    mem_addr = '0;
    if (in_range)
      mem_addr = MA_W'(int'(cmd.ttype) * DEPTH + int'(cmd.idx));
  end
endmodule

// File: rtl/tae_seq.sv
module tae_seq #(
  parameter int LATENCY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(LATENCY - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/tae_table_mem.sv
module tae_table_mem #(
  parameter int ENTRY_W = 128,
  parameter int MEM_N   = 128,
  parameter int MA_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [MA_W-1:0]    addr,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [ENTRY_W-1:0] rdata
);
  logic [ENTRY_W-1:0] mem [MEM_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/tae_engine.sv
module tae_engine
  import tae_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int DEPTH     = 16,
  parameter int LATENCY   = 3,
  localparam int ADDR_W   = $clog2(NUM_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              busy
);
  localparam int NUM_TYPES = 1 << TYPE_W;
  localparam int MEM_N     = NUM_TYPES * DEPTH;
  localparam int MA_W      = $clog2(MEM_N);
  localparam int ENTRY_W   = DATA_W * NUM_WORDS;
  localparam int WA_W      = $clog2(NUM_WORDS);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_WORDS);

  cmd_t               cmd_q;
  logic [DATA_W-1:0]  dreg [NUM_WORDS];
  logic [ENTRY_W-1:0] data_flat;
  logic [ENTRY_W-1:0] mem_rdata;
  logic [MA_W-1:0]    mem_addr;
  logic               in_range;
  logic               cmd_acc, start, done, mem_we, load_rd;

  assign cmd_acc = reg_wr && (reg_addr == CMD_ADDR) && !busy;
  assign start   = cmd_acc && reg_wdata[EXEC_POS];

  always_ff @(posedge clk) begin
    if (!rst_n)       cmd_q <= '0;
    else if (cmd_acc) cmd_q <= cmd_t'(reg_wdata[FIELD_W-1:0]);
  end

  tae_seq #(.LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  tae_decode #(.DEPTH(DEPTH), .MA_W(MA_W)) u_dec (
    .cmd(cmd_q), .in_range(in_range), .mem_addr(mem_addr)
  );

  assign mem_we  = done && cmd_q.wr && in_range;
  assign load_rd = done && !cmd_q.wr;

  tae_table_mem #(.ENTRY_W(ENTRY_W), .MEM_N(MEM_N), .MA_W(MA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
    .wdata(data_flat), .rdata(mem_rdata)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        dreg[w] <= '0;
      else if (load_rd)
        dreg[w] <= in_range ? mem_rdata[w*DATA_W +: DATA_W] : '0;
      else if (!busy && reg_wr && reg_addr == ADDR_W'(w))
        dreg[w] <= reg_wdata;
    end
    assign data_flat[w*DATA_W +: DATA_W] = dreg[w];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < CMD_ADDR) begin
      reg_rdata = dreg[reg_addr[WA_W-1:0]];
    end else if (reg_addr == CMD_ADDR) begin
      reg_rdata[FIELD_W-1:0] = cmd_q;
      reg_rdata[EXEC_POS]    = busy;
    end
  end
endmodule

// File: rtl/tae_engine_chk.sv
module tae_engine_chk #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int DEPTH     = 16,
  parameter int LATENCY   = 3,
  parameter int ADDR_W    = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          busy,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [DATA_W-1:0]             reg_wdata,
  input logic [15:0]                   cmd_fields,
  input logic [DATA_W*NUM_WORDS-1:0]   data_flat,
  input logic                          mem_we
);
  localparam int CW = $clog2(LATENCY + 2);
  logic [CW-1:0] busy_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cycles <= '0;
    else                 busy_cycles <= busy_cycles + 1'b1;
  end

  // R3: execute clears after exactly LATENCY cycles
  a_r3_exact_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'(busy_cycles) == LATENCY));
  a_r3_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(busy_cycles) < LATENCY));
  // R6: data and command fields stay put during an access
  a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_flat));
  a_r6_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_fields));
  // R7: storage is never written with an out-of-range index
  a_r7_no_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(cmd_fields[11:0]) < DEPTH));
  // R8: a command without the execute bit starts nothing
  a_r8_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && int'(reg_addr) == NUM_WORDS && !reg_wdata[16] && !busy) |=> !busy);
endmodule

bind tae_engine tae_engine_chk #(
  .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .DEPTH(DEPTH),
  .LATENCY(LATENCY), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cmd_fields(cmd_q),
  .data_flat(data_flat), .mem_we(mem_we)
);

// File: tb/tae_engine_tb.sv
module tae_engine_tb;
  localparam int LAT = 3;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_CMD = 2'd2;

  typedef struct packed {
    logic [1:0]  k;
    logic [3:0]  r;   // requirement number for messages
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] e;   // expected read value, or busy cycle count
  } vec_t;

  localparam int NV = 38;
  localparam vec_t V [NV] = '{
    // R2 data registers
    '{K_WR, 4'd2, 3'd0, 32'h11110000, 32'h0},
    '{K_WR, 4'd2, 3'd1, 32'h22220001, 32'h0},
    '{K_WR, 4'd2, 3'd2, 32'h33330002, 32'h0},
    '{K_WR, 4'd2, 3'd3, 32'h44440003, 32'h0},
    '{K_RD, 4'd2, 3'd0, 32'h0, 32'h11110000},
    '{K_RD, 4'd2, 3'd3, 32'h0, 32'h44440003},
    // R4 R3 write type 5 index 7
    '{K_CMD, 4'd4, 3'd4, 32'h0001D007, 32'd3},
    '{K_WR, 4'd4, 3'd0, 32'h0, 32'h0},
    '{K_WR, 4'd4, 3'd1, 32'h0, 32'h0},
    '{K_WR, 4'd4, 3'd2, 32'h0, 32'h0},
    '{K_WR, 4'd4, 3'd3, 32'h0, 32'h0},
    // R5 read type 5 index 7
    '{K_CMD, 4'd5, 3'd4, 32'h00015007, 32'd3},
    '{K_RD, 4'd5, 3'd0, 32'h0, 32'h11110000},
    '{K_RD, 4'd5, 3'd1, 32'h0, 32'h22220001},
    '{K_RD, 4'd5, 3'd2, 32'h0, 32'h33330002},
    '{K_RD, 4'd5, 3'd3, 32'h0, 32'h44440003},
    // R10 readback
    '{K_RD, 4'd10, 3'd4, 32'h0, 32'h00005007},
    // R5 other type, same index, is independent
    '{K_CMD, 4'd5, 3'd4, 32'h00012007, 32'd3},
    '{K_RD, 4'd5, 3'd0, 32'h0, 32'h0},
    '{K_RD, 4'd5, 3'd3, 32'h0, 32'h0},
    // R7 out of range index 16
    '{K_WR, 4'd7, 3'd0, 32'hAAAA5555, 32'h0},
    '{K_WR, 4'd7, 3'd1, 32'h5555AAAA, 32'h0},
    '{K_CMD, 4'd7, 3'd4, 32'h0001D010, 32'd3},
    '{K_CMD, 4'd7, 3'd4, 32'h00015010, 32'd3},
    '{K_RD, 4'd7, 3'd0, 32'h0, 32'h0},
    '{K_RD, 4'd7, 3'd1, 32'h0, 32'h0},
    '{K_CMD, 4'd7, 3'd4, 32'h00015000, 32'd3},
    '{K_RD, 4'd7, 3'd0, 32'h0, 32'h0},
    '{K_CMD, 4'd7, 3'd4, 32'h00015007, 32'd3},
    '{K_RD, 4'd7, 3'd0, 32'h0, 32'h11110000},
    // R8 no execute bit
    '{K_CMD, 4'd8, 3'd4, 32'h00003009, 32'd0},
    '{K_RD, 4'd8, 3'd4, 32'h0, 32'h00003009},
    // R9 unmapped addresses
    '{K_WR, 4'd9, 3'd6, 32'hFFFFFFFF, 32'h0},
    '{K_WR, 4'd9, 3'd5, 32'hFFFFFFFF, 32'h0},
    '{K_RD, 4'd9, 3'd6, 32'h0, 32'h0},
    '{K_RD, 4'd9, 3'd5, 32'h0, 32'h0},
    '{K_RD, 4'd9, 3'd7, 32'h0, 32'h0},
    '{K_RD, 4'd9, 3'd0, 32'h0, 32'h11110000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tae_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic poll(output int cycles);
    logic [31:0] v;
    cycles = 0;
    for (int i = 0; i < 50; i++) begin
      rd_reg(3'd4, v);
      if (!v[16]) break;
      cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'h0);
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), v);
      check("R1 register", v, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", V[i].r, i);
      case (V[i].k)
        K_WR: wr_reg(V[i].a, V[i].d);
        K_RD: begin rd_reg(V[i].a, v); check(tag, v, V[i].e); end
        default: begin
          wr_reg(V[i].a, V[i].d);
          poll(n);
          check(tag, 32'(n), V[i].e);
        end
      endcase
    end

    // R6: command and data writes during an access are ignored
    wr_reg(3'd0, 32'hCAFE0001);
    wr_reg(3'd4, 32'h00019004);          // write type 1 index 4
    wr_reg(3'd0, 32'hDEAD0000);          // lands while busy
    poll(n);
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd4, 32'h00011004);          // read it back
    wr_reg(3'd4, 32'h0001D00F);          // intrusive command while busy
    rd_reg(3'd4, v);
    check("R6 fields kept during busy", v, 32'h00011004);
    poll(n);
    rd_reg(3'd0, v);
    check("R6 data write ignored while busy", v, 32'hCAFE0001);
    rd_reg(3'd4, v);
    check("R6 intruding command dropped", v, 32'h00001004);
    wr_reg(3'd4, 32'h0001500F);
    poll(n);
    rd_reg(3'd0, v);
    check("R6 no write to type 5 index 15", v, 32'h0);

    // R3 busy pin follows execute
    wr_reg(3'd4, 32'h00011004);
    check("R3 busy pin high", {31'b0, busy}, 32'h1);
    poll(n);
    check("R3 busy pin low", {31'b0, busy}, 32'h0);

    // R1 reset mid-run clears registers and storage
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_reg(3'd0, v);
    check("R1 data after reset", v, 32'h0);
    wr_reg(3'd4, 32'h00015007);
    poll(n);
    rd_reg(3'd0, v);
    check("R1 entry cleared by reset", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule